// File: doc/BRIEF.md
# Mode-Banked Register Switch

This block holds the live copies of two general-purpose registers and one saved-status register, together with a private bank of all three for every processor operating mode. When the core asks to enter another mode, the block writes the three live values into the bank of the mode being left and fills the live registers from the bank of the mode being entered. Both steps happen on one clock edge, and the new mode is taken up on that same edge.

The 5-bit mode field is held inside the block and driven on an output. Six mode codes are legal and they map onto five banks. The user code (0x10) and the super-user code (0x1F) share bank 0. The privileged code (0x13) uses bank 1, trap (0x17) uses bank 2, extension (0x1B) uses bank 3 and interrupt (0x12) uses bank 4. When no swap is under way, the core updates the live registers through ordinary write ports. A request that names any other code is refused and raises a one-cycle error flag.

Top module: `mode_bank_swap`

## Requirements
- R1: A synchronous active-high reset clears all live registers and every bank entry to zero, sets the mode to privileged (0x13) and clears the error flag, all visible on the cycle after reset.
- R2: Mode codes decode to banks as follows: 0x10 and 0x1F go to bank 0, 0x13 to bank 1, 0x17 to bank 2, 0x1B to bank 3 and 0x12 to bank 4. Every other 5-bit code is unknown.
- R3: When no swap happens, a write enable that is high for a live register loads its write data on the next clock edge. The three write ports act independently of each other.
- R4: A change strobe with a known requested mode that differs from the current mode saves the three live values into the current mode's bank. On the same edge it loads the requested mode's bank into the live registers and takes up the requested mode.
- R5: A change strobe whose requested mode equals the current mode causes no save and no load, and the mode stays as it was. Any write enables in that cycle take effect as in R3.
- R6: When a swap occurs, any write enables in that same cycle are ignored, and the live registers show the restored bank values.
- R7: A change strobe with an unknown requested mode raises the error flag on the next cycle. The mode and the bank contents stay unchanged, and any write enables in that cycle take effect as in R3.
- R8: A switch between two distinct modes that share a bank (0x10 and 0x1F) leaves the live values unchanged, even though a swap is performed.
- R9: The error flag is low in every cycle that does not follow an unknown-mode request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_chg | input | 1 | Mode change request strobe |
| mode_req | input | 5 | Requested mode code |
| gpa_we | input | 1 | Write enable, first banked general register |
| gpa_wdata | input | DATA_W | Write data, first banked general register |
| gpb_we | input | 1 | Write enable, second banked general register |
| gpb_wdata | input | DATA_W | Write data, second banked general register |
| sts_we | input | 1 | Write enable, saved-status register |
| sts_wdata | input | DATA_W | Write data, saved-status register |
| gpa_q | output | DATA_W | Live first general register |
| gpb_q | output | DATA_W | Live second general register |
| sts_q | output | DATA_W | Live saved-status register |
| mode_q | output | 5 | Current mode code |
| mode_err | output | 1 | Unknown-mode request seen on the previous cycle |

## Verification
The bench starts from each of the six legal modes, loads fresh values there, and then issues a change request for all 32 codes, with a different mix of write enables each time. This finds a decoder that maps a code to the wrong bank, accepts an unknown code or rejects a legal one. Such a design would later restore values that belong to another mode, or it would raise the error flag at the wrong time. Requests that stay in the current mode would expose a design that saves and restores anyway, or one that drops a write. Writes issued during a swap would expose a design that lets the write override the restored value. The two modes that share bank 0 are aimed at a design that reads the bank before its own save lands, which would bring back old contents instead of keeping the live values.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  localparam int MODE_W    = 5;
  localparam int NUM_BANKS = 5;
  localparam int BANK_W    = $clog2(NUM_BANKS);
  localparam int NUM_REGS  = 3;

  typedef logic [MODE_W-1:0] mode_t;
  typedef logic [BANK_W-1:0] bank_t;

  localparam mode_t MODE_USER  = 5'h10;
  localparam mode_t MODE_SUPER = 5'h1F;
  localparam mode_t MODE_PRIV  = 5'h13;
  localparam mode_t MODE_TRAP  = 5'h17;
  localparam mode_t MODE_EXT   = 5'h1B;
  localparam mode_t MODE_IRQ   = 5'h12;

  typedef struct packed {
    logic  ok;
    bank_t idx;
  } bank_sel_t;
endpackage

// File: rtl/mbs_decode.sv
module mbs_decode
  import mbs_pkg::*;
(
  input  mode_t     mode,
  output bank_sel_t sel
);
  always_comb begin
    sel.ok  = 1'b1;
    sel.idx = '0;
    unique case (mode)
      MODE_USER,
      MODE_SUPER: sel.idx = bank_t'(0);
      MODE_PRIV:  sel.idx = bank_t'(1);
      MODE_TRAP:  sel.idx = bank_t'(2);
      MODE_EXT:   sel.idx = bank_t'(3);
      MODE_IRQ:   sel.idx = bank_t'(4);
      default: begin
        sel.ok  = 1'b0;
        sel.idx = '0;
      end
    endcase
  end
endmodule

// File: rtl/mbs_ctrl.sv
module mbs_ctrl
  import mbs_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  chg,
  input  mode_t req_mode,
  output mode_t mode_q,
  output logic  err_q,
  output logic  swap,
  output bank_t old_idx,
  output bank_t new_idx,
  output logic  same_bank
);
  bank_sel_t req_sel;
  bank_sel_t cur_sel;

  mbs_decode u_req_dec (.mode(req_mode), .sel(req_sel));
  mbs_decode u_cur_dec (.mode(mode_q),   .sel(cur_sel));

  logic differs;
  logic bad_req;

  assign differs   = (req_mode != mode_q);
  assign bad_req   = chg && !req_sel.ok;
  assign swap      = chg && req_sel.ok && cur_sel.ok && differs;
  assign old_idx   = cur_sel.idx;
  assign new_idx   = req_sel.idx;
  assign same_bank = (cur_sel.idx == req_sel.idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_PRIV;
      err_q  <= 1'b0;
    end else begin
      err_q <= bad_req;
      if (swap) mode_q <= req_mode;
    end
  end

  // R1
  ctrl_reset_chk: assert property (@(posedge clk)
    rst |=> (mode_q == MODE_PRIV) && !err_q);

  // R4
  mode_take_chk: assert property (@(posedge clk) disable iff (rst)
    (chg && req_sel.ok && differs) |=> (mode_q == $past(req_mode)));

  // R5
  same_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (chg && !differs) |=> $stable(mode_q));

  // R7
  bad_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (chg && !req_sel.ok) |=> (err_q && $stable(mode_q)));

  // R9
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !chg |=> !err_q);
endmodule

// File: rtl/mbs_bank.sv
module mbs_bank
  import mbs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BANKS  = NUM_BANKS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              swap,
  input  bank_t             old_idx,
  input  bank_t             new_idx,
  input  logic              same_bank,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] live_q
);
  logic [DATA_W-1:0] store [BANKS];
  logic [DATA_W-1:0] restore_val;

  assign restore_val = same_bank ? live_q : store[new_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < BANKS; b++) store[b] <= '0;
      live_q <= '0;
    end else if (swap) begin
      store[old_idx] <= live_q;
      live_q         <= restore_val;
    end else if (wr_en) begin
      live_q <= wr_data;
    end
  end

  // R1
  live_reset_chk: assert property (@(posedge clk)
    rst |=> (live_q == '0));

  // R3
  live_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!swap && wr_en) |=> (live_q == $past(wr_data)));

  // R8
  shared_bank_chk: assert property (@(posedge clk) disable iff (rst)
    (swap && same_bank) |=> $stable(live_q));

  // R4
  save_old_chk: assert property (@(posedge clk) disable iff (rst)
    swap |=> (store[$past(old_idx)] == $past(live_q)));
endmodule

// File: rtl/mode_bank_swap.sv
module mode_bank_swap
  import mbs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_chg,
  input  logic [4:0]        mode_req,
  input  logic              gpa_we,
  input  logic [DATA_W-1:0] gpa_wdata,
  input  logic              gpb_we,
  input  logic [DATA_W-1:0] gpb_wdata,
  input  logic              sts_we,
  input  logic [DATA_W-1:0] sts_wdata,
  output logic [DATA_W-1:0] gpa_q,
  output logic [DATA_W-1:0] gpb_q,
  output logic [DATA_W-1:0] sts_q,
  output logic [4:0]        mode_q,
  output logic              mode_err
);
  logic  swap;
  logic  same_bank;
  bank_t old_idx;
  bank_t new_idx;
  mode_t cur_mode;

  logic [NUM_REGS-1:0]             we_vec;
  logic [NUM_REGS-1:0][DATA_W-1:0] wd_vec;
  logic [NUM_REGS-1:0][DATA_W-1:0] q_vec;

  assign we_vec = {sts_we, gpb_we, gpa_we};
  assign wd_vec = {sts_wdata, gpb_wdata, gpa_wdata};

  mbs_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .chg       (mode_chg),
    .req_mode  (mode_req),
    .mode_q    (cur_mode),
    .err_q     (mode_err),
    .swap      (swap),
    .old_idx   (old_idx),
    .new_idx   (new_idx),
    .same_bank (same_bank)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    mbs_bank #(.DATA_W(DATA_W), .BANKS(NUM_BANKS)) u_bank (
      .clk       (clk),
      .rst       (rst),
      .swap      (swap),
      .old_idx   (old_idx),
      .new_idx   (new_idx),
      .same_bank (same_bank),
      .wr_en     (we_vec[g]),
      .wr_data   (wd_vec[g]),
      .live_q    (q_vec[g])
    );
  end

  assign gpa_q  = q_vec[0];
  assign gpb_q  = q_vec[1];
  assign sts_q  = q_vec[2];
  assign mode_q = cur_mode;
endmodule

// File: tb/mode_bank_swap_tb.sv
`timescale 1ns/1ps
module mode_bank_swap_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        mode_chg;
  logic [4:0]  mode_req;
  logic        gpa_we, gpb_we, sts_we;
  logic [31:0] gpa_wdata, gpb_wdata, sts_wdata;
  logic [31:0] gpa_q, gpb_q, sts_q;
  logic [4:0]  mode_q;
  logic        mode_err;

  int checks = 0;
  int errors = 0;

  logic [31:0] eb [5][3];
  logic [31:0] el [3];
  logic [4:0]  emode;
  logic        eerr;

  always #4 clk = ~clk;

  mode_bank_swap #(.DATA_W(32)) u_dut (
    .clk(clk), .rst(rst), .mode_chg(mode_chg), .mode_req(mode_req),
    .gpa_we(gpa_we), .gpa_wdata(gpa_wdata),
    .gpb_we(gpb_we), .gpb_wdata(gpb_wdata),
    .sts_we(sts_we), .sts_wdata(sts_wdata),
    .gpa_q(gpa_q), .gpb_q(gpb_q), .sts_q(sts_q),
    .mode_q(mode_q), .mode_err(mode_err)
  );

  // R2 mapping, computed independently of the design
  function automatic int bank_of(input logic [4:0] m);
    case (m)
      5'h10, 5'h1F: return 0;
      5'h13: return 1;
      5'h17: return 2;
      5'h1B: return 3;
      5'h12: return 4;
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] mk(input int a, input int b, input int c);
    return {8'(a), 8'(b), 8'(c), 8'hA5};
  endfunction

  task automatic idle_inputs();
    mode_chg = 1'b0; mode_req = 5'h00;
    gpa_we = 1'b0; gpb_we = 1'b0; sts_we = 1'b0;
    gpa_wdata = '0; gpb_wdata = '0; sts_wdata = '0;
  endtask

  task automatic compare(input string tag);
    checks++;
    if (gpa_q !== el[0] || gpb_q !== el[1] || sts_q !== el[2] ||
        mode_q !== emode || mode_err !== eerr) begin
      errors++;
      $display("FAIL %s: actual %h/%h/%h mode=%h err=%b expected %h/%h/%h mode=%h err=%b",
               tag, gpa_q, gpb_q, sts_q, mode_q, mode_err,
               el[0], el[1], el[2], emode, eerr);
    end
  endtask

  task automatic step(input logic chg, input logic [4:0] req, input logic [2:0] we,
                      input logic [31:0] d0, input logic [31:0] d1, input logic [31:0] d2,
                      input string tag);
    int nb;
    int ob;
    @(negedge clk);
    mode_chg = chg; mode_req = req;
    gpa_we = we[0]; gpb_we = we[1]; sts_we = we[2];
    gpa_wdata = d0; gpb_wdata = d1; sts_wdata = d2;
    nb = bank_of(req);
    ob = bank_of(emode);
    eerr = 1'b0;
    if (chg && nb >= 0 && req != emode) begin
      for (int k = 0; k < 3; k++) eb[ob][k] = el[k];
      for (int k = 0; k < 3; k++) el[k] = eb[nb][k];
      emode = req;
    end else begin
      if (we[0]) el[0] = d0;
      if (we[1]) el[1] = d1;
      if (we[2]) el[2] = d2;
      eerr = chg && (nb < 0);
    end
    @(negedge clk);
    idle_inputs();
    compare(tag);
  endtask

  initial begin
    logic [4:0] vm [6];
    vm[0] = 5'h10; vm[1] = 5'h1F; vm[2] = 5'h13;
    vm[3] = 5'h17; vm[4] = 5'h1B; vm[5] = 5'h12;
    idle_inputs();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int b = 0; b < 5; b++)
      for (int k = 0; k < 3; k++) eb[b][k] = '0;
    for (int k = 0; k < 3; k++) el[k] = '0;
    emode = 5'h13;
    eerr  = 1'b0;
    @(negedge clk);
    compare("R1 reset state");

    for (int ci = 0; ci < 6; ci++) begin
      if (emode != vm[ci])
        step(1'b1, vm[ci], 3'b000, '0, '0, '0, "R2 R4 enter mode");
      step(1'b0, 5'h00, 3'b111, mk(ci, 200, 0), mk(ci, 200, 1), mk(ci, 200, 2), "R3 write all");
      for (int r = 0; r < 32; r++) begin
        string tag;
        logic [2:0] we;
        int rb;
        we = 3'(r + ci);
        rb = bank_of(5'(r));
        if (rb < 0)                          tag = "R7 unknown mode";
        else if (5'(r) == emode)             tag = "R5 same mode";
        else if (rb == bank_of(emode))       tag = "R8 shared bank";
        else if (we != 3'b000)               tag = "R6 write during swap R2 R4";
        else                                 tag = "R2 R4 swap";
        step(1'b1, 5'(r), we, mk(ci, r, 0), mk(ci, r, 1), mk(ci, r, 2), tag);
        if (rb < 0)
          step(1'b0, 5'h00, 3'b000, '0, '0, '0, "R9 error clears");
        if (emode != vm[ci])
          step(1'b1, vm[ci], 3'b000, '0, '0, '0, "R4 return");
        step(1'b0, 5'h00, 3'(r), mk(ci, r, 10), mk(ci, r, 11), mk(ci, r, 12), "R3 partial write");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule